// File: doc/BRIEF.md
# Lockable Thermal Throttle Controller

This block holds an 8-bit configuration register for thermal protection and turns zone flags from an on-die temperature sensor into two outputs. The first is a throttle request for the clock or power actuator. The second is an active-low platform trip line that shuts the system down. Software writes the register through a single-cycle write port and reads it back at any time.

The sensor supplies three comparator flags: hot, aux2 and catastrophic. It also supplies a separate direct catastrophic trip line. Configuration fields choose the following:

- whether throttling is enabled;
- whether the aux2 zone takes part in throttling;
- whether the catastrophic comparator or the direct trip line feeds the shutdown path;
- whether a catastrophic event halts the platform.

A lock bit, once written to 1, freezes the whole register until hardware reset. A shutdown, once taken, stays latched until hardware reset.

Top module: `thr_ctrl`

## Requirements
- R1: After reset, `rd_data` reads 8'h00, `throttle_req` is 0 and `trip_n` is 1.
- R2: While unlocked, a write stores data bits 7 (throttle enable), 5 (trip source), 4 (zone select), 3 (halt on catastrophic) and 0 (lock). The stored value is visible on `rd_data` from the first clock edge after the write. Bits 6, 2 and 1 always read 0, whatever is written.
- R3: Once bit 0 reads 1, every later write leaves all of `rd_data` unchanged.
- R4: Writing 0 to bit 0 never clears the lock. Only an assertion of `rst_n` clears it, and the register is writable again after that reset.
- R5: With bit 7 at 0, `throttle_req` is 0 for every combination of zone flags.
- R6: With bit 7 at 1 and bit 4 at 0, `throttle_req` is combinationally the OR of `zone_hot`, `zone_aux2` and `zone_cat`.
- R7: With bit 7 at 1 and bit 4 at 1, `throttle_req` is the OR of `zone_hot` and `zone_cat`, and `zone_aux2` has no effect.
- R8: With bit 5 at 0, the shutdown path is driven by `zone_cat`, and `cat_trip_direct` has no effect on `trip_n`.
- R9: With bit 5 at 1, the shutdown path is driven by `cat_trip_direct`, and `zone_cat` has no effect on `trip_n`.
- R10: With bit 3 at 0, `trip_n` stays 1 whatever the sensor inputs do.
- R11: `trip_n` goes to 0 after the first clock edge at which bit 3 is 1 and the selected catastrophic source is 1. It then stays 0, even after the source drops, until `rst_n` is asserted. The trip path does not depend on bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Current register contents |
| zone_hot | input | 1 | Sensor is above the hot threshold |
| zone_aux2 | input | 1 | Sensor is above the aux2 threshold |
| zone_cat | input | 1 | Sensor comparator is above the catastrophic threshold |
| cat_trip_direct | input | 1 | Direct catastrophic trip line from the sensor |
| throttle_req | output | 1 | Throttle request, combinational |
| trip_n | output | 1 | Platform thermal trip, active low, latched |

## Verification
The assertions take the sensor flags and write port to be synchronous to `clk` and stable around its rising edge. The bench keeps within this by changing every input only on the falling edge. The checks also take `rst_n` as the only way the lock and the trip latch return to 0. The stimulus therefore places a reset before each new configuration instead of trying to unlock by writing. The bench sweeps all 256 write values, and every configuration against every zone flag combination, with a fresh reset for each. The inputs then never carry a latched trip from one case into the next.

// File: rtl/thr_pkg.sv
package thr_pkg;
   localparam int CFG_W    = 8;
   localparam int POS_EN   = 7;
   localparam int POS_SRC  = 5;
   localparam int POS_ZSEL = 4;
   localparam int POS_HOC  = 3;
   localparam int POS_LOCK = 0;
   localparam int ZONE_N   = 3;
   localparam int Z_HOT    = 0;
   localparam int Z_AUX2   = 1;
   localparam int Z_CAT    = 2;

   function automatic logic [CFG_W-1:0] store_mask();
      logic [CFG_W-1:0] m;
      m = '0;
      m[POS_EN]   = 1'b1;
      m[POS_SRC]  = 1'b1;
      m[POS_ZSEL] = 1'b1;
      m[POS_HOC]  = 1'b1;
      m[POS_LOCK] = 1'b1;
      return m;
   endfunction

   function automatic logic [ZONE_N-1:0] narrow_zones();
      logic [ZONE_N-1:0] m;
      m = '1;
      m[Z_AUX2] = 1'b0;
      return m;
   endfunction
endpackage

// File: rtl/thr_cfg_reg.sv
module thr_cfg_reg #(
   parameter int W = 8,
   parameter int LOCK_POS = 0,
   parameter logic [W-1:0] KEEP_MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] cfg_q
);
   generate
      if (LOCK_POS >= W) begin : g_bad_lock
         $error("lock position outside register");
      end
      if (!KEEP_MASK[LOCK_POS]) begin : g_bad_mask
         $error("lock bit must be a stored bit");
      end
   endgenerate

   logic wr_ok;
   assign wr_ok = wr_en & ~cfg_q[LOCK_POS];

   logic unused_wr_bits;
   assign unused_wr_bits = ^(wr_data & ~KEEP_MASK);

   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         if (i == LOCK_POS) begin : g_lock
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  cfg_q[i] <= 1'b0;
               else if (wr_ok && wr_data[i])
                  cfg_q[i] <= 1'b1;
            end
         end else if (KEEP_MASK[i]) begin : g_store
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  cfg_q[i] <= 1'b0;
               else if (wr_ok)
                  cfg_q[i] <= wr_data[i];
            end
         end else begin : g_rsvd
            assign cfg_q[i] = 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/thr_zone_sel.sv
module thr_zone_sel #(
   parameter int NZ = 3,
   parameter logic [NZ-1:0] NARROW = '1
) (
   input  logic          enable,
   input  logic          narrow,
   input  logic [NZ-1:0] zones,
   output logic          throttle
);
   generate
      if (NZ < 1) begin : g_bad_nz
         $error("need at least one zone");
      end
   endgenerate

   logic [NZ-1:0] live;
   assign live = narrow ? NARROW : {NZ{1'b1}};

   always_comb begin
      throttle = 1'b0;
      for (int k = 0; k < NZ; k++)
         throttle = throttle | (zones[k] & live[k]);
      throttle = throttle & enable;
   end
endmodule

// File: rtl/thr_trip_latch.sv
module thr_trip_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic halt_en,
   input  logic use_direct,
   input  logic cat_cmp,
   input  logic cat_direct,
   output logic trip_n
);
   logic cat_sel;
   logic tripped;

   assign cat_sel = use_direct ? cat_direct : cat_cmp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tripped <= 1'b0;
      else if (halt_en && cat_sel)
         tripped <= 1'b1;
   end

   assign trip_n = ~tripped;
endmodule

// File: rtl/thr_ctrl.sv
module thr_ctrl #(
   parameter int CFG_W = thr_pkg::CFG_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CFG_W-1:0] wr_data,
   output logic [CFG_W-1:0] rd_data,
   input  logic             zone_hot,
   input  logic             zone_aux2,
   input  logic             zone_cat,
   input  logic             cat_trip_direct,
   output logic             throttle_req,
   output logic             trip_n
);
   import thr_pkg::*;

   localparam logic [CFG_W-1:0] KEEP = store_mask();

   generate
      if (CFG_W != thr_pkg::CFG_W) begin : g_bad_w
         $error("register width fixed by field layout");
      end
   endgenerate

   logic [CFG_W-1:0]  cfg;
   logic [ZONE_N-1:0] zones;

   assign zones[Z_HOT]  = zone_hot;
   assign zones[Z_AUX2] = zone_aux2;
   assign zones[Z_CAT]  = zone_cat;

   thr_cfg_reg #(.W(CFG_W), .LOCK_POS(POS_LOCK), .KEEP_MASK(KEEP)) u_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .cfg_q(cfg)
   );

   thr_zone_sel #(.NZ(ZONE_N), .NARROW(narrow_zones())) u_zone (
      .enable(cfg[POS_EN]), .narrow(cfg[POS_ZSEL]), .zones(zones),
      .throttle(throttle_req)
   );

   thr_trip_latch u_trip (
      .clk(clk), .rst_n(rst_n), .halt_en(cfg[POS_HOC]),
      .use_direct(cfg[POS_SRC]), .cat_cmp(zone_cat),
      .cat_direct(cat_trip_direct), .trip_n(trip_n)
   );

   assign rd_data = cfg;
endmodule

// File: rtl/thr_ctrl_chk.sv
module thr_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [7:0] wr_data,
   input logic [7:0] rd_data,
   input logic       zone_hot,
   input logic       zone_aux2,
   input logic       zone_cat,
   input logic       cat_trip_direct,
   input logic       throttle_req,
   input logic       trip_n
);
   // R2
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[6] == 1'b0 && rd_data[2:1] == 2'b00);
   // R2
   write_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !rd_data[0]) |=> rd_data[7] == $past(wr_data[7]) &&
                                  rd_data[3] == $past(wr_data[3]));
   // R3
   locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[0] |=> $stable(rd_data));
   // R4
   lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[0] |=> rd_data[0]);
   // R5
   no_enable_no_throttle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_data[7] |-> !throttle_req);
   // R6
   hot_throttles_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[7] && zone_hot) |-> throttle_req);
   // R7
   narrow_skips_aux2_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[4] && !zone_hot && !zone_cat) |-> !throttle_req);
   // R10
   trip_needs_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(trip_n) |-> $past(rd_data[3] &&
                         (rd_data[5] ? cat_trip_direct : zone_cat)));
   // R11
   trip_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !trip_n |=> !trip_n);
endmodule

bind thr_ctrl thr_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
   .rd_data(rd_data), .zone_hot(zone_hot), .zone_aux2(zone_aux2),
   .zone_cat(zone_cat), .cat_trip_direct(cat_trip_direct),
   .throttle_req(throttle_req), .trip_n(trip_n)
);

// File: tb/sim_thr_ctrl.sv
`timescale 1ns/1ps
module sim_thr_ctrl;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       zone_hot = 1'b0, zone_aux2 = 1'b0, zone_cat = 1'b0;
   logic       cat_trip_direct = 1'b0;
   logic       throttle_req, trip_n;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   thr_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .zone_hot(zone_hot), .zone_aux2(zone_aux2),
      .zone_cat(zone_cat), .cat_trip_direct(cat_trip_direct),
      .throttle_req(throttle_req), .trip_n(trip_n)
   );

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      zone_hot = 0; zone_aux2 = 0; zone_cat = 0; cat_trip_direct = 0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic do_write(logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual hung expected finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1 reset state
      check("R1 rd", rd_data, 8'h00);
      check("R1 thr", {7'd0, throttle_req}, 8'd0);
      check("R1 trip", {7'd0, trip_n}, 8'd1);

      // R2 every write value, reserved bits dropped
      for (int d = 0; d < 256; d++) begin
         do_reset();
         do_write(d[7:0]);
         check("R2 store", rd_data, d[7:0] & 8'hB9);
      end

      // R3 and R4 lock behaviour
      do_reset();
      do_write(8'h99);
      check("R3 locked value", rd_data, 8'h99);
      do_write(8'h66);
      check("R3 write ignored", rd_data, 8'h99);
      do_write(8'h00);
      check("R4 zero keeps lock", rd_data, 8'h99);
      do_reset();
      check("R4 reset clears", rd_data, 8'h00);
      do_write(8'hB8);
      check("R4 writable after reset", rd_data, 8'hB8);

      // R5..R11 sweep: every config against every sensor input pattern
      for (int c = 0; c < 16; c++) begin
         for (int z = 0; z < 16; z++) begin
            logic en, src, zs, hoc, h, a, ct, dr, exp_thr, exp_cat;
            logic [7:0] cfg;
            en = c[3]; src = c[2]; zs = c[1]; hoc = c[0];
            h = z[0]; a = z[1]; ct = z[2]; dr = z[3];
            cfg = {en, 1'b0, src, zs, hoc, 3'b000};
            exp_thr = en & (h | ct | (a & ~zs));
            exp_cat = hoc & (src ? dr : ct);
            do_reset();
            do_write(cfg);
            zone_hot = h; zone_aux2 = a; zone_cat = ct; cat_trip_direct = dr;
            #1;
            // R5 R6 R7 combinational throttle
            check(en ? (zs ? "R7 throttle" : "R6 throttle") : "R5 throttle",
                  {7'd0, throttle_req}, {7'd0, exp_thr});
            @(negedge clk);
            // R8 R9 R10 trip source and halt enable
            check(hoc ? (src ? "R9 trip" : "R8 trip") : "R10 trip",
                  {7'd0, trip_n}, {7'd0, ~exp_cat});
            zone_hot = 0; zone_aux2 = 0; zone_cat = 0; cat_trip_direct = 0;
            @(negedge clk);
            @(negedge clk);
            // R11 latched after the source drops
            check("R11 sticky", {7'd0, trip_n}, {7'd0, ~exp_cat});
         end
      end

      // R11 released only by reset, independent of enable
      do_reset();
      do_write(8'h08);
      zone_cat = 1'b1;
      @(negedge clk);
      check("R11 trip without enable", {7'd0, trip_n}, 8'd0);
      do_reset();
      check("R11 reset releases", {7'd0, trip_n}, 8'd1);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule